// File: doc/BRIEF.md
# Multi-Source Reset Stretcher

This block merges three requests for a chip-wide reset into one active-high system reset. The requests are a supply-low flag from an analog comparator, an active-low external reset pin and a one-cycle overflow pulse from a watchdog. The supply flag and the pin are asynchronous, so each passes through a two-flop synchroniser. The pin must also stay low for a minimum number of consecutive clocks before it counts. The reset stays asserted while a held cause (supply low or qualified pin) is present. Once every held cause is gone, the reset stays asserted for a fixed stretch period (`STRETCH_CYC` clocks) and then releases. A watchdog pulse has no held phase, so it starts a full stretch at once.

A three-state machine drives the output. `ST_HOLD` is entered from any state when a held cause is active, and it moves to `ST_STRETCH` once no held cause remains. `ST_STRETCH` counts the period. It returns to `ST_HOLD` if a held cause comes back, it reloads the counter and stays put on a watchdog pulse, and it moves to `ST_RUN` when the count expires. `ST_RUN` is the only state in which the reset is released. From `ST_RUN` the machine goes to `ST_HOLD` on a held cause or to `ST_STRETCH` on a watchdog pulse. Power-on reset (`por_n`) places the machine in `ST_STRETCH` with a full count. A 2-bit code records the most recent trigger.

Top module: `rststr_top`

## Requirements
- R1: While `por_n` is low, `sys_rst` is 1 and `rst_cause` is 0 (power-up). After `por_n` rises, `sys_rst` falls on exactly the `STRETCH_CYC`-th rising clock edge.
- R2: Let `lowv_flag` rise to 1 (supply low) just after an edge, with `sys_rst` at 0. `sys_rst` becomes 1 on the third edge that follows, because of two synchroniser flops and the state register.
- R3: Let `lowv_flag` be high for L edges starting from edge 1. `sys_rst` then falls on edge L+3+`STRETCH_CYC`.
- R4: A pin low for at least `QUAL_CYC` consecutive edges is accepted. Counting from the first low edge, `sys_rst` rises on edge `QUAL_CYC`+3.
- R5: A pin low for fewer than `QUAL_CYC` consecutive edges has no effect on `sys_rst` or `rst_cause`. The same holds for a low period that is broken by a high sample before it reaches `QUAL_CYC`, because the width count clears on every high sample.
- R6: After an accepted pin low of N edges (N >= `QUAL_CYC`), `sys_rst` falls on edge N+4+`STRETCH_CYC`.
- R7: Let `wdog_ovf` be high for one edge (edge 1) while `sys_rst` is 0. `sys_rst` is 1 after that edge and falls on edge 1+`STRETCH_CYC`.
- R8: A cause arriving during the stretch restarts it. A held cause restarts the count once the cause clears. A watchdog pulse reloads the count on its own edge.
- R9: `rst_cause` holds the code of the most recent trigger: 1 for supply low, 2 for an accepted pin reset and 3 for the watchdog. A watchdog pulse that arrives while a held cause is active still updates the code.
- R10: While a held cause is active, `sys_rst` is 1 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| lowv_flag | input | 1 | Supply-below-threshold flag, asynchronous, 1 = low |
| ext_rst_n | input | 1 | External reset pin, asynchronous, active low |
| wdog_ovf | input | 1 | Watchdog overflow, one-cycle synchronous pulse |
| sys_rst | output | 1 | Merged system reset, active high |
| rst_cause | output | 2 | Most recent trigger: 0 power-up, 1 supply, 2 pin, 3 watchdog |

## Verification
The hardest case to reach is a fresh cause that lands inside a stretch that is already counting. The count has to restart, not carry on or add to the remaining cycles. To get there, directed runs re-apply the supply flag or a second watchdog pulse a fixed number of cycles after the first cause has cleared. The release edge then shows whether the count restarted. Qualification is probed from its edges with a pulse exactly one clock short of the limit, and with a low period that has a single high sample in the middle.

// File: rtl/rststr_pkg.sv
package rststr_pkg;
    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_STRETCH = 2'd1,
        ST_RUN     = 2'd2
    } rst_state_e;

    typedef enum logic [1:0] {
        CAUSE_POWERUP = 2'd0,
        CAUSE_LOWV    = 2'd1,
        CAUSE_PIN     = 2'd2,
        CAUSE_WDOG    = 2'd3
    } rst_cause_e;
endpackage

// File: rtl/rststr_sync.sv
module rststr_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic por_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n) chain <= RST_VAL;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rststr_pin_qual.sv
module rststr_pin_qual #(
    parameter int QUAL_CYC = 10
) (
    input  logic clk,
    input  logic por_n,
    input  logic pin_s,
    output logic hold
);
    localparam int CW = $clog2(QUAL_CYC + 1);
    localparam logic [CW-1:0] LIM = CW'(QUAL_CYC);

    logic [CW-1:0] width_cnt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                width_cnt <= '0;
        else if (pin_s)            width_cnt <= '0;
        else if (width_cnt != LIM) width_cnt <= width_cnt + 1'b1;
    end

    assign hold = (width_cnt == LIM);

    // R5: any high sample wipes the qualification
    a_r5_high_clears: assert property (@(posedge clk) disable iff (!por_n)
        pin_s |=> !hold);
endmodule

// File: rtl/rststr_stretch_ctr.sv
module rststr_stretch_ctr #(
    parameter int STRETCH_CYC = 1200
) (
    input  logic clk,
    input  logic por_n,
    input  logic load,
    output logic done
);
    localparam int CNT_W = (STRETCH_CYC > 2) ? $clog2(STRETCH_CYC) : 1;
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(STRETCH_CYC - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)          cnt <= LOAD_VAL;
        else if (load)       cnt <= LOAD_VAL;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/rststr_top.sv
module rststr_top #(
    parameter int STRETCH_CYC = 1200,
    parameter int QUAL_CYC    = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       lowv_flag,
    input  logic       ext_rst_n,
    input  logic       wdog_ovf,
    output logic       sys_rst,
    output logic [1:0] rst_cause
);
    import rststr_pkg::*;

    logic lowv_s, pin_s, pin_hold, cause_act, stretch_done, ctr_load;
    logic lowv_prev, pin_prev;
    rst_state_e state, state_nxt;
    rst_cause_e cause_q;

    rststr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_lowv (
        .clk(clk), .por_n(por_n), .d(lowv_flag), .q(lowv_s));

    rststr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_pin (
        .clk(clk), .por_n(por_n), .d(ext_rst_n), .q(pin_s));

    rststr_pin_qual #(.QUAL_CYC(QUAL_CYC)) u_pin_qual (
        .clk(clk), .por_n(por_n), .pin_s(pin_s), .hold(pin_hold));

    rststr_stretch_ctr #(.STRETCH_CYC(STRETCH_CYC)) u_ctr (
        .clk(clk), .por_n(por_n), .load(ctr_load), .done(stretch_done));

    assign cause_act = lowv_s | pin_hold;
    assign ctr_load  = (state != ST_STRETCH) | wdog_ovf;

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state <= ST_STRETCH;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_HOLD: begin
                if (!cause_act) state_nxt = ST_STRETCH;
            end
            ST_STRETCH: begin
                if (cause_act)                      state_nxt = ST_HOLD;
                else if (!wdog_ovf && stretch_done) state_nxt = ST_RUN;
            end
            ST_RUN: begin
                if (cause_act)     state_nxt = ST_HOLD;
                else if (wdog_ovf) state_nxt = ST_STRETCH;
            end
            default: state_nxt = ST_HOLD;
        endcase
    end

    // trigger record
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            lowv_prev <= 1'b0;
            pin_prev  <= 1'b0;
            cause_q   <= CAUSE_POWERUP;
        end else begin
            lowv_prev <= lowv_s;
            pin_prev  <= pin_hold;
            if (lowv_s && !lowv_prev)     cause_q <= CAUSE_LOWV;
            else if (pin_hold && !pin_prev) cause_q <= CAUSE_PIN;
            else if (wdog_ovf)            cause_q <= CAUSE_WDOG;
        end
    end

    // outputs
    always_comb begin
        sys_rst   = (state != ST_RUN);
        rst_cause = cause_q;
    end

    a_r10_held_cause_asserts: assert property (@(posedge clk) disable iff (!por_n)
        cause_act |=> sys_rst);

    a_r7_wdog_asserts: assert property (@(posedge clk) disable iff (!por_n)
        wdog_ovf |=> sys_rst);

    a_r3_release_after_count: assert property (@(posedge clk) disable iff (!por_n)
        $fell(sys_rst) |-> ($past(stretch_done) && !$past(cause_act)));

    a_r8_stretch_interrupted: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_STRETCH && cause_act) |=> (state == ST_HOLD));
endmodule

// File: tb/rststr_top_tb_top.sv
module rststr_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int S = 32;
    localparam int Q = 10;
    localparam int K_LV = 0, K_PIN = 1, K_WDT = 2;

    typedef struct packed {
        int kind; int len; int rise; int fall; int cause;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{K_LV,  5,     3, 5 + 3 + S,     1},
        '{K_LV,  1,     3, 1 + 3 + S,     1},
        '{K_PIN, Q,     Q + 3, Q + 4 + S, 2},
        '{K_PIN, Q + 7, Q + 3, Q + 11 + S, 2},
        '{K_PIN, Q - 1, 0, 0,             2},
        '{K_WDT, 1,     1, 1 + S,         3}
    };

    logic clk = 1'b0, por_n = 1'b0;
    logic lowv_flag = 1'b0, ext_rst_n = 1'b1, wdog_ovf = 1'b0;
    logic sys_rst;
    logic [1:0] rst_cause;
    int n_checks = 0, n_fail = 0;

    rststr_top #(.STRETCH_CYC(S), .QUAL_CYC(Q), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .por_n(por_n), .lowv_flag(lowv_flag), .ext_rst_n(ext_rst_n),
        .wdog_ovf(wdog_ovf), .sys_rst(sys_rst), .rst_cause(rst_cause));

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // masks: bit i set = cause active before edge i+1 (pin mask 1 = pin low)
    task automatic run_masks(input logic [63:0] lv_m, input logic [63:0] pin_m,
                             input logic [63:0] wd_m, input int win,
                             output int rise, output int fall);
        rise = 0; fall = 0;
        for (int i = 0; i < win; i++) begin
            lowv_flag = (i < 64) ? lv_m[i] : 1'b0;
            ext_rst_n = (i < 64) ? !pin_m[i] : 1'b1;
            wdog_ovf  = (i < 64) ? wd_m[i] : 1'b0;
            @(posedge clk);
            #(CLK_PERIOD / 4);
            if (rise == 0 && sys_rst) rise = i + 1;
            else if (rise != 0 && fall == 0 && !sys_rst) fall = i + 1;
        end
        lowv_flag = 1'b0; ext_rst_n = 1'b1; wdog_ovf = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run hung actual=%0d expected=%0d", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int rise, fall;
        logic [63:0] m;
        // R1: power-up
        #(CLK_PERIOD * 3 + CLK_PERIOD / 4);
        check(sys_rst == 1'b1, "R1", "sys_rst in por", sys_rst, 1);
        check(rst_cause == 2'd0, "R1", "cause in por", rst_cause, 0);
        por_n = 1'b1;
        fall = 0;
        for (int i = 0; i < S + 8; i++) begin
            @(posedge clk);
            #(CLK_PERIOD / 4);
            if (fall == 0 && !sys_rst) fall = i + 1;
        end
        check(fall == S, "R1", "power-up release edge", fall, S);

        // table walk: R2 R3 R4 R5 R6 R7 R9
        for (int v = 0; v < 6; v++) begin
            m = (64'd1 << VECS[v].len) - 64'd1;
            run_masks(VECS[v].kind == K_LV ? m : 64'd0,
                      VECS[v].kind == K_PIN ? m : 64'd0,
                      VECS[v].kind == K_WDT ? m : 64'd0,
                      VECS[v].len + S + 8, rise, fall);
            case (VECS[v].kind)
                K_LV: begin
                    check(rise == VECS[v].rise, "R2", "lowv rise edge", rise, VECS[v].rise);
                    check(fall == VECS[v].fall, "R3", "lowv fall edge", fall, VECS[v].fall);
                end
                K_PIN: begin
                    if (VECS[v].rise == 0) begin
                        check(rise == 0, "R5", "short pin rise edge", rise, 0);
                    end else begin
                        check(rise == VECS[v].rise, "R4", "pin rise edge", rise, VECS[v].rise);
                        check(fall == VECS[v].fall, "R6", "pin fall edge", fall, VECS[v].fall);
                    end
                end
                default: begin
                    check(rise == VECS[v].rise, "R7", "wdog rise edge", rise, VECS[v].rise);
                    check(fall == VECS[v].fall, "R7", "wdog fall edge", fall, VECS[v].fall);
                end
            endcase
            check(rst_cause == 2'(VECS[v].cause), "R9", "cause code", rst_cause, VECS[v].cause);
        end

        // R5: low period broken by one high sample
        run_masks(64'd0, 64'h1FBF, 64'd0, 13 + S + 8, rise, fall);
        check(rise == 0, "R5", "broken pin low rise edge", rise, 0);
        check(rst_cause == 2'd3, "R5", "cause untouched", rst_cause, 3);

        // R8: second watchdog pulse inside stretch
        run_masks(64'd0, 64'd0, (64'd1 << 10) | 64'd1, 11 + S + 8, rise, fall);
        check(fall == 11 + S, "R8", "wdog reload release edge", fall, 11 + S);

        // R8: supply low again during stretch
        run_masks((64'd7 << 12) | 64'hF, 64'd0, 64'd0, 18 + S + 8, rise, fall);
        check(rise == 3, "R8", "lowv rise edge", rise, 3);
        check(fall == 18 + S, "R8", "lowv restart release edge", fall, 18 + S);

        // R9: watchdog during supply hold updates cause, release from supply
        run_masks(64'hFF, 64'd0, 64'd1 << 4, 11 + S + 8, rise, fall);
        check(fall == 11 + S, "R9", "release during mixed causes", fall, 11 + S);
        check(rst_cause == 2'd3, "R9", "cause after wdog in hold", rst_cause, 3);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule